// File: doc/BRIEF.md
# SPI Transmitter with Buffer-Level DMA Requests

This block is the transmit half of an SPI master. Frames wait in a two-entry holding buffer and move one at a time into a shift register, which sends them most significant bit first on MOSI. SCLK idles low and is used in mode 0: MOSI is updated when SCLK falls and is sampled by the receiver when SCLK rises. The SCLK period is twice a programmable half-period, counted in system clocks, so the fastest rate is half the system clock.

Two level outputs drive a DMA engine. `txbl_o` means the holding buffer is empty, and the engine may refill it. `txempty_o` means the buffer and the shifter are both empty, so the line has gone quiet. Data comes in through two write ports. The single port adds one frame. The double port adds two frames in one write, which lets an engine fill the whole buffer on one request.

When the last bit of a frame ends and another frame is waiting, that frame is loaded on the same cycle. With 16-bit frames at half the system clock, this keeps the line streaming without gaps. A write that cannot be accepted is dropped and raises a sticky overflow flag.

Top module: `spi_dma_tx`

## Requirements
- R1: While reset is held, and after it is released, SCLK and MOSI are low, `txbl_o` and `txempty_o` are high, and `ovf_o` is low.
- R2: While a frame is shifting, SCLK is low for H system clocks and then high for H system clocks, where H is `half_period_i`, or 1 when that input is 0. SCLK is low whenever the shifter is idle.
- R3: MOSI shows the most significant unsent bit of the current frame. It changes only on the cycle SCLK falls or on the cycle a frame is loaded, and it is low when the shifter is idle.
- R4: With `wide_i` = 0, a frame sends bits 7 down to 0 of the written word. With `wide_i` = 1, it sends bits 15 down to 0. The width is taken from `wide_i` on the cycle the frame enters the shifter.
- R5: `txbl_o` is high exactly when the holding buffer holds no frame.
- R6: `txempty_o` is high exactly when the buffer and the shifter are both empty. If the buffer is empty when the final SCLK fall of a frame occurs, `txempty_o` rises on that same cycle.
- R7: If a frame is buffered when the final SCLK fall of the current frame occurs, that frame is loaded on the same cycle. No idle bit time is inserted.
- R8: A double write places bits 15:0 as the earlier frame and bits 31:16 as the later frame. It is accepted only if the buffer is empty before the write.
- R9: Whether a write fits is judged on the buffer occupancy before that cycle's load. A single write to a full buffer, or a double write to a non-empty buffer, is dropped and sets `ovf_o`. `ovf_o` stays set until an `ovf_clr_i` pulse on a cycle with no dropped write.
- R10: When single and double writes arrive on the same cycle, only the double write is considered. The single write is ignored and does not count as dropped.
- R11: A write to an idle block lands in the buffer on the next clock edge. The shifter loads the frame on the edge after that, and from then on `txbl_o` is high again while `txempty_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period_i | input | DIV_W | SCLK half-period in system clocks (0 acts as 1); hold stable while shifting |
| wide_i | input | 1 | Frame width: 0 = 8 bits, 1 = 16 bits |
| wr_one_i | input | 1 | Single-frame write strobe |
| wr_one_data_i | input | 16 | Single-frame data |
| wr_two_i | input | 1 | Double-frame write strobe |
| wr_two_data_i | input | 32 | Two frames; low half goes out first |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| sclk_o | output | 1 | SPI clock, idles low |
| mosi_o | output | 1 | Serial data out |
| txbl_o | output | 1 | Request: buffer empty |
| txempty_o | output | 1 | Request: buffer and shifter empty |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench streams 16-bit frames at the fastest rate and refills the buffer whenever `txbl_o` rises. If the refill were loaded one cycle late, `txempty_o` would flash high between frames and each bit time after it would slip by a cycle.

It also writes on consecutive cycles while a load happens on the same cycle. If the design judged room after the pop, it would accept a frame that should have been dropped, and the overflow flag would stay low.

A double write issued together with a single write shows whether the single write is wrongly queued. A double write to a non-empty buffer shows whether that write is wrongly split. An 8-bit frame written with distinct high and low bytes shows whether the wrong byte is shifted out. A half-period of zero and a half-period of three check that the divider neither stalls nor miscounts.

// File: rtl/spi_dma_tx_pkg.sv
package spi_dma_tx_pkg;
  localparam int FRAME_W = 16;
  localparam int HALF_W  = FRAME_W / 2;
  localparam int BITS_W  = $clog2(FRAME_W + 1);

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [BITS_W-1:0]  bits_t;

  // number of bits in a frame for the selected width
  function automatic bits_t frame_bits(input logic wide);
    return wide ? bits_t'(FRAME_W) : bits_t'(HALF_W);
  endfunction

  // left-align a frame so the bit to send is always the top bit
  function automatic frame_t align_frame(input frame_t d, input logic wide);
    return wide ? d : {d[HALF_W-1:0], {HALF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/spi_dma_tx_buf.sv
module spi_dma_tx_buf
  import spi_dma_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_one_i,
  input  frame_t               one_data_i,
  input  logic                 wr_two_i,
  input  logic [2*FRAME_W-1:0] two_data_i,
  input  logic                 pop_i,
  output frame_t               head_o,
  output logic                 empty_o,
  output logic                 drop_o
);
  localparam logic [1:0] FULL = 2'd2;

  frame_t     ent_q [2];
  logic [1:0] cnt_q;
  logic [1:0] cnt_after_pop;
  logic       acc_one, acc_two;

  always_comb begin
    // room is judged on the occupancy before this cycle's pop
    acc_two       = wr_two_i && (cnt_q == 2'd0);
    acc_one       = wr_one_i && !wr_two_i && (cnt_q != FULL);
    drop_o        = (wr_two_i && (cnt_q != 2'd0)) || (wr_one_i && !wr_two_i && (cnt_q == FULL));
    cnt_after_pop = cnt_q - {1'b0, pop_i};
    head_o        = ent_q[0];
    empty_o       = (cnt_q == 2'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= 2'd0;
      ent_q[0] <= '0;
      ent_q[1] <= '0;
    end else begin
      if (pop_i) ent_q[0] <= ent_q[1];
      if (acc_two) begin
        ent_q[0] <= two_data_i[FRAME_W-1:0];
        ent_q[1] <= two_data_i[2*FRAME_W-1:FRAME_W];
      end else if (acc_one) begin
        if (cnt_after_pop == 2'd0) ent_q[0] <= one_data_i;
        else                       ent_q[1] <= one_data_i;
      end
      cnt_q <= cnt_after_pop + {1'b0, acc_one} + (acc_two ? 2'd2 : 2'd0);
    end
  end
endmodule

// File: rtl/spi_dma_tx_shift.sv
module spi_dma_tx_shift
  import spi_dma_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_i,
  input  logic             wide_i,
  input  logic             avail_i,
  input  frame_t           frame_i,
  output logic             take_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  function automatic logic [DIV_W-1:0] half_limit(input logic [DIV_W-1:0] h);
    return (h == '0) ? ONE : h;
  endfunction

  logic             busy_q, sclk_q;
  logic [DIV_W-1:0] pcnt_q, lim;
  bits_t            left_q;
  frame_t           sh_q;
  logic             tick;

  always_comb begin
    lim    = half_limit(half_i);
    tick   = busy_q && (pcnt_q == lim - ONE);
    // final falling edge of the frame
    done_o = tick && sclk_q && (left_q == bits_t'(1));
    take_o = avail_i && (!busy_q || done_o);
    sclk_o = sclk_q;
    mosi_o = busy_q && sh_q[FRAME_W-1];
    busy_o = busy_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      pcnt_q <= '0;
      left_q <= '0;
      sh_q   <= '0;
    end else if (take_o) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      pcnt_q <= '0;
      left_q <= frame_bits(wide_i);
      sh_q   <= align_frame(frame_i, wide_i);
    end else if (tick) begin
      pcnt_q <= '0;
      sclk_q <= ~sclk_q;
      if (sclk_q) begin
        if (left_q == bits_t'(1)) begin
          busy_q <= 1'b0;
        end else begin
          sh_q   <= sh_q << 1;
          left_q <= left_q - bits_t'(1);
        end
      end
    end else if (busy_q) begin
      pcnt_q <= pcnt_q + ONE;
    end
  end
endmodule

// File: rtl/spi_dma_tx.sv
module spi_dma_tx
  import spi_dma_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     half_period_i,
  input  logic                 wide_i,
  input  logic                 wr_one_i,
  input  logic [FRAME_W-1:0]   wr_one_data_i,
  input  logic                 wr_two_i,
  input  logic [2*FRAME_W-1:0] wr_two_data_i,
  input  logic                 ovf_clr_i,
  output logic                 sclk_o,
  output logic                 mosi_o,
  output logic                 txbl_o,
  output logic                 txempty_o,
  output logic                 ovf_o
);
  frame_t head;
  logic   buf_empty, drop, take, sh_busy, frame_done;
  logic   ovf_q;

  spi_dma_tx_buf u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_one_i   (wr_one_i),
    .one_data_i (wr_one_data_i),
    .wr_two_i   (wr_two_i),
    .two_data_i (wr_two_data_i),
    .pop_i      (take),
    .head_o     (head),
    .empty_o    (buf_empty),
    .drop_o     (drop)
  );

  spi_dma_tx_shift #(.DIV_W(DIV_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .half_i  (half_period_i),
    .wide_i  (wide_i),
    .avail_i (!buf_empty),
    .frame_i (head),
    .take_o  (take),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .busy_o  (sh_busy),
    .done_o  (frame_done)
  );

  // a drop wins over a clear on the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)         ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  always_comb begin
    txbl_o    = buf_empty;
    txempty_o = buf_empty && !sh_busy;
    ovf_o     = ovf_q;
  end
endmodule

// File: rtl/spi_dma_tx_chk.sv
module spi_dma_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic txbl,
  input logic txempty,
  input logic ovf,
  input logic ovf_clr,
  input logic wr_double,
  input logic busy,
  input logic done
);
  a_r2_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r6_empty_implies_bl: assert property (@(posedge clk) disable iff (!rst_n)
    txempty |-> txbl);

  a_r7_refill_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !txbl) |=> (busy && !txempty));

  a_r8_double_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_double && !txbl) |=> ovf);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
endmodule

bind spi_dma_tx spi_dma_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk_o),
  .mosi      (mosi_o),
  .txbl      (txbl_o),
  .txempty   (txempty_o),
  .ovf       (ovf_o),
  .ovf_clr   (ovf_clr_i),
  .wr_double (wr_two_i),
  .busy      (sh_busy),
  .done      (frame_done)
);

// File: tb/spi_dma_tx_bench.sv
module spi_dma_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half = 8'd1;
  logic        wide = 1'b0;
  logic        wr_single = 1'b0;
  logic [15:0] sd = '0;
  logic        wr_double = 1'b0;
  logic [31:0] dd = '0;
  logic        ovf_clr = 1'b0;
  logic        sclk, mosi, txbl, txempty, ovf;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  spi_dma_tx u_spi_dma_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .half_period_i (half),
    .wide_i        (wide),
    .wr_one_i      (wr_single),
    .wr_one_data_i (sd),
    .wr_two_i      (wr_double),
    .wr_two_data_i (dd),
    .ovf_clr_i     (ovf_clr),
    .sclk_o        (sclk),
    .mosi_o        (mosi),
    .txbl_o        (txbl),
    .txempty_o     (txempty),
    .ovf_o         (ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural reference: frame queue plus a time index within the frame
  int q[$];
  bit m_busy = 0;
  int m_t = 0, m_n = 8, m_fr = 0;
  bit m_ovf = 0;

  function automatic int eff_h();
    return (half == 0) ? 1 : int'(half);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_t = 0; m_n = 8; m_fr = 0; m_ovf = 0;
    end else begin
      int h, sz, fr;
      bit end_now, ld, drop;
      h = eff_h(); sz = q.size(); fr = 0; drop = 0;
      end_now = m_busy && (m_t == 2*h*m_n - 1);
      ld = (sz > 0) && (!m_busy || end_now);
      if (ld) fr = q.pop_front();
      if (wr_double) begin
        if (sz == 0) begin q.push_back(int'(dd[15:0])); q.push_back(int'(dd[31:16])); end
        else drop = 1;
      end else if (wr_single) begin
        if (sz < 2) q.push_back(int'(sd)); else drop = 1;
      end
      if (drop) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (ld) begin m_fr = fr; m_n = wide ? 16 : 8; m_t = 0; m_busy = 1; end
      else if (end_now) m_busy = 0;
      else if (m_busy) m_t++;
    end
  end

  // per-cycle comparison against the reference, plus a serial receiver
  logic [31:0] rx = '0;
  int rx_bits = 0;
  logic prev_sclk = 1'b0;
  bit streaming = 0;
  int gap_cycles = 0;
  int last_rise = 0, rise_period = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int h, e_sclk, e_mosi;
      h = eff_h();
      e_sclk = (m_busy && ((m_t / h) % 2 == 1)) ? 1 : 0;
      e_mosi = m_busy ? ((m_fr >> (m_n - 1 - m_t / (2*h))) & 1) : 0;
      chk("R2", "sclk", int'(sclk), e_sclk);
      chk("R3", "mosi", int'(mosi), e_mosi);
      chk("R5", "txbl", int'(txbl), (q.size() == 0) ? 1 : 0);
      chk("R6", "txempty", int'(txempty), (!m_busy && q.size() == 0) ? 1 : 0);
      chk("R9", "ovf", int'(ovf), int'(m_ovf));
      if (sclk && !prev_sclk) begin
        rx = {rx[30:0], mosi};
        rx_bits++;
        rise_period = cyc - last_rise;
        last_rise = cyc;
      end
      if (streaming && txempty) gap_cycles++;
    end
    prev_sclk = sclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (txempty) break;
    end
    @(negedge clk);
  endtask

  task automatic put_one(input logic [15:0] d);
    @(negedge clk); wr_single = 1; sd = d;
    @(negedge clk); wr_single = 0;
  endtask

  task automatic put_two(input logic [31:0] d);
    @(negedge clk); wr_double = 1; dd = d;
    @(negedge clk); wr_double = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "sclk in reset", int'(sclk), 0);
    chk("R1", "mosi in reset", int'(mosi), 0);
    chk("R1", "txbl in reset", int'(txbl), 1);
    chk("R1", "txempty in reset", int'(txempty), 1);
    chk("R1", "ovf in reset", int'(ovf), 0);
    rst_n = 1;
    @(negedge clk);

    // R4 and R11: 8-bit frame sends the low byte, with one cycle of latency
    half = 8'd1; wide = 0; rx_bits = 0;
    @(negedge clk); wr_single = 1; sd = 16'hBEEF;
    @(negedge clk); wr_single = 0;
    chk("R11", "txbl after write lands", int'(txbl), 0);
    chk("R11", "txempty after write lands", int'(txempty), 0);
    @(negedge clk);
    chk("R11", "txbl after load", int'(txbl), 1);
    chk("R11", "txempty after load", int'(txempty), 0);
    wait_idle();
    chk("R4", "8-bit bit count", rx_bits, 8);
    chk("R4", "8-bit byte sent", int'(rx[7:0]), 16'hEF);

    // R7 and R8: 16-bit stream at half the system clock, refilled on each request
    wide = 1; rx_bits = 0; gap_cycles = 0;
    put_two(32'hCAFE_1234);
    streaming = 1;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (txbl) break;
      end
      wr_double = 1; dd = {16'h1111 * 16'(k + 1), 16'h0F0F ^ 16'(k)};
      @(negedge clk); wr_double = 0;
    end
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txbl) break;
    end
    streaming = 0;
    wait_idle();
    chk("R7", "idle cycles inside stream", gap_cycles, 0);
    chk("R7", "bits in stream", rx_bits, 128);
    chk("R8", "last double-write order", int'(rx), 32'h0F0D_3333);

    // R2: half-period three gives a six-cycle SCLK period
    half = 8'd3; wide = 0; rx_bits = 0;
    put_one(16'h00C3);
    wait_idle();
    chk("R2", "sclk period half=3", rise_period, 6);
    chk("R4", "byte at half=3", int'(rx[7:0]), 8'hC3);

    // R2: half-period zero acts as one
    half = 8'd0; rx_bits = 0;
    put_one(16'h005A);
    wait_idle();
    chk("R2", "sclk period half=0", rise_period, 2);

    // R9: back-to-back writes with a load on the same cycle
    half = 8'd4; wide = 1; rx_bits = 0;
    @(negedge clk); wr_single = 1; sd = 16'hA001;
    @(negedge clk); sd = 16'hB002;
    @(negedge clk); sd = 16'hC003;
    @(negedge clk); sd = 16'hD004;
    @(negedge clk); wr_single = 0;
    chk("R9", "ovf after write to full buffer", int'(ovf), 1);
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    chk("R9", "ovf after clear", int'(ovf), 0);
    put_two(32'h7777_6666);
    chk("R8", "double write to non-empty buffer", int'(ovf), 1);
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    wait_idle();
    chk("R9", "frames sent", rx_bits, 48);
    chk("R9", "last two frames", int'(rx), 32'hB002_C003);

    // R10: single and double together, only the double counts
    half = 8'd1; rx_bits = 0;
    @(negedge clk); wr_single = 1; sd = 16'h00AA; wr_double = 1; dd = 32'h5555_3333;
    @(negedge clk); wr_single = 0; wr_double = 0;
    wait_idle();
    chk("R10", "ovf stays low", int'(ovf), 0);
    chk("R10", "bits sent", rx_bits, 32);
    chk("R10", "frames sent", int'(rx), 32'h3333_5555);

    // R1: a reset in the middle of a frame returns the idle state
    put_one(16'hFFFF);
    repeat (5) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "sclk after reset", int'(sclk), 0);
    chk("R1", "txempty after reset", int'(txempty), 1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule